// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the decode stage of a processor that supports a hypervisor mode. For each system-level operation it receives, it decides whether the operation may run. The operations are wait-for-interrupt, the supervisor address-translation fence, the hypervisor fence and the hypervisor virtual-machine loads and stores. The decision uses the current privilege level, whether virtualization is on, and three status controls: a wait-trap bit, a translation-trap bit and a user-hypervisor-access bit.

A legal operation produces its own effect. Wait-for-interrupt raises a halt request, which holds until a wake input is seen. A fence raises a TLB-flush request. A hypervisor access raises a two-stage-lookup strobe together with the checked access size and signedness. An operation that may not run raises an illegal-instruction exception instead. All results are registered, and each accepted operation asserts exactly one of the four outputs. The memory access itself, the TLB and the interrupt sources are handled by neighbouring blocks.

Top module: `priv_op_gate`

## Requirements
- R1: Operation code 1 (wait-for-interrupt) is illegal when virtualization is on, or when privilege is supervisor (1) and the wait-trap bit is set. Otherwise it raises the halt request.
- R2: Operation code 2 (address-translation fence) is illegal in user mode (0), and illegal in supervisor mode with the translation-trap bit set. Otherwise it raises the flush request.
- R3: Operation code 3 (hypervisor fence) is legal in machine mode (3), and legal in supervisor mode with virtualization off. In every other case it is illegal, and a legal one raises the flush request.
- R4: Hypervisor accesses (codes 4 load, 5 store, 6 execute-load) are permitted in three cases: machine mode; supervisor mode with virtualization off; user mode with virtualization off and the user-hypervisor-access bit set. Otherwise they are illegal.
- R5: A permitted hypervisor load accepts every size encoding (0 byte, 1 halfword, 2 word, 3 doubleword). It reports the size on acc_size_o. It reports the sign flag on acc_signed_o, except for a doubleword, which is reported unsigned.
- R6: A permitted hypervisor store accepts every size and always reports acc_signed_o low, whatever the sign input.
- R7: A hypervisor execute-load accepts only unsigned halfword or unsigned word. Any other size or a set sign flag makes it illegal.
- R8: An operation presented on a clock edge shows its result on the outputs after that edge. The exception, flush and lookup strobe last exactly one cycle per operation.
- R9: The halt request stays high until wake_i is seen high on a clock edge and drops on that edge. Operations presented while halted have no effect.
- R10: Each accepted operation asserts exactly one of illegal_o, halt_o, flush_o, stage2_o. Code 0 asserts none of them, and code 7 is illegal.
- R11: Privilege encoding 2 is reserved, and every operation from it is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | Operation presented this cycle |
| op_i | input | 3 | Operation code |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| virt_i | input | 1 | Virtualization enabled |
| wait_trap_i | input | 1 | Wait-trap status bit |
| xlat_trap_i | input | 1 | Translation-trap status bit |
| user_hacc_i | input | 1 | User-hypervisor-access status bit |
| size_i | input | 2 | Hypervisor access size encoding |
| signed_i | input | 1 | Hypervisor access sign flag |
| wake_i | input | 1 | Wake condition (pending interrupt) |
| illegal_o | output | 1 | Illegal-instruction exception pulse |
| halt_o | output | 1 | Halt request (held) |
| flush_o | output | 1 | TLB-flush request pulse |
| stage2_o | output | 1 | Two-stage-lookup strobe pulse |
| acc_size_o | output | 2 | Checked access size |
| acc_signed_o | output | 1 | Checked access signedness |

## Verification
The bench targets the cases where one status bit decides the outcome: wait-trap in user versus supervisor mode, translation-trap in machine mode, and the user-hypervisor-access bit with virtualization on. A gate that ignored virtualization, or applied a bit at the wrong level, would flush or halt where it should trap. The bench also tries the size corners: signed doubleword loads, signed stores and every rejected execute-load form. A wrong size check would either let a bad access through or report a sign that should be cleared. Halt behaviour is tested with operations sent while halted and with a late wake. A design that dropped the halt early, or acted on the blocked operation, would show a stray pulse.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;
    localparam int OPC_BITS  = 3;
    localparam int PRV_BITS  = 2;
    localparam int SIZE_BITS = 2;

    typedef enum logic [OPC_BITS-1:0] {
        OP_NONE   = 3'd0,
        OP_WFI    = 3'd1,
        OP_SFENCE = 3'd2,
        OP_HFENCE = 3'd3,
        OP_HLD    = 3'd4,
        OP_HST    = 3'd5,
        OP_HLDX   = 3'd6,
        OP_RSVD   = 3'd7
    } op_e;

    typedef enum logic [PRV_BITS-1:0] {
        PRV_USR = 2'd0,
        PRV_SUP = 2'd1,
        PRV_RSV = 2'd2,
        PRV_MCH = 2'd3
    } prv_e;

    typedef enum logic [SIZE_BITS-1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef struct packed {
        logic                 illegal;
        logic                 halt;
        logic                 flush;
        logic                 stage2;
        logic [SIZE_BITS-1:0] size;
        logic                 sgn;
    } gate_st_t;
endpackage

// File: rtl/priv_perm_chk.sv
module priv_perm_chk
    import priv_gate_pkg::*;
(
    input  op_e  op,
    input  prv_e priv,
    input  logic virt,
    input  logic wait_trap,
    input  logic xlat_trap,
    input  logic user_hacc,
    output logic allow,
    output logic is_flush,
    output logic is_hacc
);
    logic hyp_ok;

    always_comb begin
        hyp_ok = (priv == PRV_MCH)
              || (priv == PRV_SUP && !virt)
              || (priv == PRV_USR && !virt && user_hacc);
        is_flush = (op == OP_SFENCE) || (op == OP_HFENCE);
        is_hacc  = (op == OP_HLD) || (op == OP_HST) || (op == OP_HLDX);
        unique case (op)
            OP_WFI:    allow = !(virt || (priv == PRV_SUP && wait_trap));
            OP_SFENCE: allow = (priv == PRV_MCH) || (priv == PRV_SUP && !xlat_trap);
            OP_HFENCE: allow = (priv == PRV_MCH) || (priv == PRV_SUP && !virt);
            OP_HLD, OP_HST, OP_HLDX: allow = hyp_ok;
            default:   allow = 1'b0;
        endcase
        if (priv == PRV_RSV) allow = 1'b0;
    end
endmodule

// File: rtl/priv_size_chk.sv
module priv_size_chk
    import priv_gate_pkg::*;
(
    input  op_e   op,
    input  size_e size,
    input  logic  sgn,
    output logic  size_ok,
    output logic  sgn_out
);
    always_comb begin
        size_ok = 1'b1;
        sgn_out = 1'b0;
        unique case (op)
            OP_HLD:  sgn_out = sgn && (size != SZ_DBL);
            OP_HST:  sgn_out = 1'b0;
            OP_HLDX: size_ok = !sgn && (size == SZ_HALF || size == SZ_WORD);
            default: size_ok = 1'b1;
        endcase
    end
endmodule

// File: rtl/priv_op_gate.sv
module priv_op_gate
    import priv_gate_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid_i,
    input  logic [OPC_BITS-1:0]  op_i,
    input  logic [PRV_BITS-1:0]  priv_i,
    input  logic                 virt_i,
    input  logic                 wait_trap_i,
    input  logic                 xlat_trap_i,
    input  logic                 user_hacc_i,
    input  logic [SIZE_BITS-1:0] size_i,
    input  logic                 signed_i,
    input  logic                 wake_i,
    output logic                 illegal_o,
    output logic                 halt_o,
    output logic                 flush_o,
    output logic                 stage2_o,
    output logic [SIZE_BITS-1:0] acc_size_o,
    output logic                 acc_signed_o
);
    op_e      op;
    logic     allow, is_flush, is_hacc, size_ok, sgn_chk, take;
    gate_st_t st_d, st_q;

    assign op = op_e'(op_i);

    priv_perm_chk u_perm (
        .op        (op),
        .priv      (prv_e'(priv_i)),
        .virt      (virt_i),
        .wait_trap (wait_trap_i),
        .xlat_trap (xlat_trap_i),
        .user_hacc (user_hacc_i),
        .allow     (allow),
        .is_flush  (is_flush),
        .is_hacc   (is_hacc)
    );

    priv_size_chk u_size (
        .op      (op),
        .size    (size_e'(size_i)),
        .sgn     (signed_i),
        .size_ok (size_ok),
        .sgn_out (sgn_chk)
    );

    assign take = op_valid_i && !st_q.halt;

    always_comb begin
        st_d         = '0;
        st_d.halt    = st_q.halt && !wake_i;
        st_d.size    = st_q.size;
        st_d.sgn     = st_q.sgn;
        if (take && op != OP_NONE) begin
            if (!allow || !size_ok) begin
                st_d.illegal = 1'b1;
            end else if (op == OP_WFI) begin
                st_d.halt = 1'b1;
            end else if (is_flush) begin
                st_d.flush = 1'b1;
            end else if (is_hacc) begin
                st_d.stage2 = 1'b1;
                st_d.size   = size_i;
                st_d.sgn    = sgn_chk;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign illegal_o    = st_q.illegal;
    assign halt_o       = st_q.halt;
    assign flush_o      = st_q.flush;
    assign stage2_o     = st_q.stage2;
    assign acc_size_o   = st_q.size;
    assign acc_signed_o = st_q.sgn;

    // R10
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({illegal_o, flush_o, stage2_o}) && !(halt_o && (flush_o || stage2_o)));
    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o && !wake_i |=> halt_o);
    // R9
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o && wake_i |=> !halt_o);
    // R9
    blocked_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> !illegal_o && !flush_o && !stage2_o);
    // R1
    wfi_virt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !halt_o && op_i == OP_WFI && virt_i |=> illegal_o);
    // R11
    rsv_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i && !halt_o && op_i != OP_NONE && priv_i == PRV_RSV |=> illegal_o);
    // R5
    dbl_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stage2_o && acc_size_o == SZ_DBL |-> !acc_signed_o);
    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> !illegal_o && !flush_o && !stage2_o);
endmodule

// File: tb/priv_op_gate_tb.sv
module priv_op_gate_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid_i = 1'b0;
    logic [2:0] op_i = '0;
    logic [1:0] priv_i = '0;
    logic       virt_i = 1'b0, wait_trap_i = 1'b0, xlat_trap_i = 1'b0, user_hacc_i = 1'b0;
    logic [1:0] size_i = '0;
    logic       signed_i = 1'b0, wake_i = 1'b0;
    logic       illegal_o, halt_o, flush_o, stage2_o, acc_signed_o;
    logic [1:0] acc_size_o;
    int         n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    priv_op_gate u_dut (.*);

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got ill/halt/fl/s2/sz/sg=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] outs();
        return {illegal_o, halt_o, flush_o, stage2_o, acc_size_o, acc_signed_o};
    endfunction

    // one operation, outputs sampled one cycle later at negedge
    task automatic run_op(input logic [2:0] op, input logic [1:0] pv, input logic vt,
                          input logic tw, input logic tv, input logic hu,
                          input logic [1:0] sz, input logic sg);
        @(negedge clk);
        op_valid_i = 1'b1; op_i = op; priv_i = pv; virt_i = vt;
        wait_trap_i = tw; xlat_trap_i = tv; user_hacc_i = hu; size_i = sz; signed_i = sg;
        @(negedge clk);
        op_valid_i = 1'b0;
    endtask

    task automatic wake_up();
        @(negedge clk); wake_i = 1'b1;
        @(negedge clk); wake_i = 1'b0;
    endtask

    // shorthand result codes (size/sign only matter for lookups)
    localparam logic [6:0] ILL = 7'b1000000, HLT = 7'b0100000, FLU = 7'b0010000, NIL = 7'b0000000;

    task automatic t_reset();
        check("R8 reset", outs(), NIL);
    endtask

    task automatic t_wfi();
        run_op(3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R1 wfi sup tw", outs() & 7'b1110000, ILL);
        run_op(3'd1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R1 wfi virt", outs() & 7'b1110000, ILL);
        run_op(3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R1 wfi user tw", outs() & 7'b1110000, HLT);
        wake_up();
        check("R9 wake clears", outs() & 7'b1110000, NIL);
    endtask

    task automatic t_sfence();
        run_op(3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R2 sfence user", outs() & 7'b1110000, ILL);
        run_op(3'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        check("R2 sfence sup tvm", outs() & 7'b1110000, ILL);
        run_op(3'd2, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
        check("R2 sfence mach tvm", outs() & 7'b1110000, FLU);
        @(negedge clk);
        check("R8 flush one cycle", outs() & 7'b1110000, NIL);
    endtask

    task automatic t_hfence();
        run_op(3'd3, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R3 hfence sup virt", outs() & 7'b1110000, ILL);
        run_op(3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R3 hfence sup", outs() & 7'b1110000, FLU);
        run_op(3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
        check("R3 hfence user", outs() & 7'b1110000, ILL);
    endtask

    task automatic t_hacc();
        run_op(3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1);
        check("R4 user hu load", outs(), 7'b0001001);
        @(negedge clk);
        check("R8 strobe one cycle", outs() & 7'b1111000, NIL);
        run_op(3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
        check("R4 user hu virt", outs() & 7'b1111000, ILL);
        run_op(3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R4 user no hu", outs() & 7'b1111000, ILL);
        run_op(3'd5, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R4 sup virt", outs() & 7'b1111000, ILL);
        run_op(3'd5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0);
        check("R4 mach virt store", outs(), 7'b0001100);
    endtask

    task automatic t_sizes();
        for (int s = 0; s < 4; s++) begin
            run_op(3'd4, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'(s), 1'b1);
            check("R5 signed load", outs(), {4'b0001, 2'(s), (s != 3) ? 1'b1 : 1'b0});
            run_op(3'd5, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 2'(s), 1'b1);
            check("R6 store sign dropped", outs(), {4'b0001, 2'(s), 1'b0});
        end
    endtask

    task automatic t_exec();
        for (int s = 0; s < 4; s++) begin
            for (int g = 0; g < 2; g++) begin
                run_op(3'd6, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'(s), 1'(g));
                if (g == 0 && (s == 1 || s == 2))
                    check("R7 exec ok", outs(), {4'b0001, 2'(s), 1'b0});
                else
                    check("R7 exec bad", outs() & 7'b1111000, ILL);
            end
        end
    endtask

    task automatic t_halt_block();
        run_op(3'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R9 halt set", outs() & 7'b1111000, HLT);
        run_op(3'd2, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R9 op ignored while halted", outs() & 7'b1111000, HLT);
        run_op(3'd7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R9 bad op ignored while halted", outs() & 7'b1111000, HLT);
        repeat (5) @(negedge clk);
        check("R9 halt held", outs() & 7'b1111000, HLT);
        wake_up();
        check("R9 halt released", outs() & 7'b1111000, NIL);
    endtask

    task automatic t_misc();
        run_op(3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R10 code 0 silent", outs() & 7'b1111000, NIL);
        run_op(3'd7, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R10 code 7 illegal", outs() & 7'b1111000, ILL);
        run_op(3'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R11 reserved priv fence", outs() & 7'b1111000, ILL);
        run_op(3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
        check("R11 reserved priv wfi", outs() & 7'b1111000, ILL);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wfi();
        t_sfence();
        t_hfence();
        t_hacc();
        t_sizes();
        t_exec();
        t_halt_block();
        t_misc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule